// File: doc/BRIEF.md
# DMA Bus-Tenure Request Controller

This block sits between an internal serial DMA engine and the shared system bus. When the DMA channel logic asks for an operand transfer, the controller requests the bus and raises a bus-clear output. Other masters can use that output to leave the bus. Once the grant arrives, the controller drops bus-clear, runs the access cycles for exactly one operand, and then gives the bus back. It acknowledges the channel with a single-cycle pulse.

The operand is either a byte or a 16-bit word. On a 16-bit data bus every operand takes one bus cycle. On an 8-bit data bus a word is split into a lower-byte cycle and an upper-byte cycle, and the bus is held between them. A halt input lets a running cycle finish and then holds off any new cycle. A bus error or a retry ends the operand at once, even between the two halves of a split word. A synchronous reset aborts everything. A low-interrupt-latency release control is brought in from the system, but this controller ignores it.

All outputs are registered. The bus-cycle logic sees a level `cyc_go` that stays high while accesses are wanted. Each `cyc_done` pulse taken while `cyc_go` is high ends one bus cycle.

Top module: `dma_bus_tenure`

## Requirements
- R1: From the clock edge that accepts a transfer request (`xfer_req`=1 with `halt`=0 while idle), `bus_req` and `bus_clr` are both 1 until the grant starts the first access. `bus_clr` is never 1 unless `bus_req` is 1.
- R2: While an access is running (`cyc_go`=1), `bus_clr` is 0. The first access starts on the edge after `bus_grant`=1 is seen with `halt`=0.
- R3: One cycle after the last access of an operand completes, `bus_req` is 0. Every tenure serves exactly one operand.
- R4: With `bus_byte`=1 (8-bit bus) and `xfer_word`=1 (16-bit operand), two access cycles run. `cyc_hi`=0 marks the lower byte and `cyc_hi`=1 marks the upper byte. `bus_req` stays 1 between the two cycles.
- R5: A byte operand (`xfer_word`=0), or any operand with `bus_byte`=0, takes exactly one access cycle.
- R6: `rst`=1 at a clock edge clears `bus_req`, `bus_clr`, `cyc_go`, `cyc_hi`, `xfer_ack` and `xfer_err`. The block then returns to idle with no pending request.
- R7: `halt`=1 never ends a running access. After that access ends, no new access starts and no new request is accepted until `halt` returns to 0.
- R8: `bus_err`=1 together with `cyc_done` ends the operand, even after only the lower half of a split word. It gives a one-cycle `xfer_err`, no `xfer_ack`, and releases the bus.
- R9: `retry`=1 together with `cyc_done` (and `bus_err`=0) ends the operand and releases the bus, with neither `xfer_ack` nor `xfer_err`.
- R10: `lat_release` has no effect on any output.
- R11: `xfer_ack` is a one-cycle pulse, given in the same cycle that `bus_req` falls after an error-free operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, aborts all activity |
| xfer_req | input | 1 | Channel asks for one operand transfer (sampled when idle) |
| xfer_word | input | 1 | 1 = 16-bit operand, 0 = byte operand |
| xfer_ack | output | 1 | One-cycle pulse: operand finished without error |
| xfer_err | output | 1 | One-cycle pulse: operand ended by bus error |
| bus_req | output | 1 | Bus request, held for the whole tenure |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_clr | output | 1 | Asks other masters to clear the bus |
| bus_byte | input | 1 | 1 = 8-bit data bus, 0 = 16-bit data bus |
| cyc_go | output | 1 | Access cycles wanted; each cyc_done ends one |
| cyc_hi | output | 1 | 1 = current access carries the upper byte |
| cyc_done | input | 1 | Current access cycle terminated |
| bus_err | input | 1 | Bus error qualifier for cyc_done |
| retry | input | 1 | Retry qualifier for cyc_done |
| halt | input | 1 | Suspend after the current access |
| lat_release | input | 1 | Low-latency release control, ignored |

## Verification
The bench goes after the split word on a byte-wide bus. A design that released the bus after the lower byte, or skipped the upper-byte cycle, would show `bus_req` low or `cyc_hi` wrong in the second beat. It drives a bus error and a retry on the first half of a split word, where a faulty controller would go on to the upper byte or give a stray acknowledge. It raises halt both in the middle of an access and between beats: a design that cut the running cycle short, or started the upper beat while halted, shows the wrong `cyc_go`. It also drives reset in the middle of an access, where a surviving request would leave `bus_req` set.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_CYC_LO  = 3'd2,
    ST_CYC_HI  = 3'd3,
    ST_RELEASE = 3'd4
  } dbt_state_e;

  typedef struct packed {
    logic bus_req;
    logic bus_clr;
    logic cyc_go;
    logic cyc_hi;
    logic ack;
    logic err;
  } dbt_out_t;

  localparam dbt_out_t OUT_IDLE = '0;

endpackage

// File: rtl/dbt_next.sv
module dbt_next
  import dbt_pkg::*;
(
  input  dbt_state_e state_q,
  input  logic       two_q,
  input  logic       go_q,
  input  logic       xfer_req,
  input  logic       xfer_word,
  input  logic       bus_byte,
  input  logic       bus_grant,
  input  logic       halt,
  input  logic       cyc_done,
  input  logic       bus_err,
  input  logic       retry,
  output dbt_state_e state_n,
  output logic       two_n,
  output dbt_out_t   out_n
);

  logic done_evt;
  logic abort;
  logic last_beat;
  logic in_cyc;

  // a termination only counts while a cycle is actually requested
  assign done_evt  = cyc_done && go_q;
  assign abort     = bus_err || retry;
  assign last_beat = (state_q == ST_CYC_HI) || ((state_q == ST_CYC_LO) && !two_q);

  always_comb begin
    state_n = state_q;
    two_n   = two_q;
    case (state_q)
      ST_IDLE: begin
        if (xfer_req && !halt) begin
          state_n = ST_REQ;
          two_n   = xfer_word && bus_byte;
        end
      end
      ST_REQ: begin
        if (bus_grant && !halt) state_n = ST_CYC_LO;
      end
      ST_CYC_LO: begin
        if (done_evt) begin
          if (abort)      state_n = ST_RELEASE;
          else if (two_q) state_n = ST_CYC_HI;
          else            state_n = ST_RELEASE;
        end
      end
      ST_CYC_HI: begin
        if (done_evt) state_n = ST_RELEASE;
      end
      ST_RELEASE: begin
        state_n = ST_IDLE;
        two_n   = 1'b0;
      end
      default: begin
        state_n = ST_IDLE;
        two_n   = 1'b0;
      end
    endcase
  end

  assign in_cyc = (state_n == ST_CYC_LO) || (state_n == ST_CYC_HI);

  always_comb begin
    out_n         = OUT_IDLE;
    out_n.bus_req = (state_n == ST_REQ) || in_cyc;
    out_n.bus_clr = (state_n == ST_REQ);
    // a running cycle is never cut by halt; a new one waits for halt low
    out_n.cyc_go  = in_cyc && ((go_q && !done_evt) || !halt);
    out_n.cyc_hi  = (state_n == ST_CYC_HI);
    out_n.ack     = done_evt && !abort && last_beat;
    out_n.err     = done_evt && bus_err;
  end

endmodule

// File: rtl/dbt_regs.sv
module dbt_regs
  import dbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dbt_state_e state_n,
  input  logic       two_n,
  input  dbt_out_t   out_n,
  output dbt_state_e state_q,
  output logic       two_q,
  output dbt_out_t   out_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      two_q   <= 1'b0;
      out_q   <= OUT_IDLE;
    end else begin
      state_q <= state_n;
      two_q   <= two_n;
      out_q   <= out_n;
    end
  end

endmodule

// File: rtl/dma_bus_tenure.sv
module dma_bus_tenure
  import dbt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic xfer_req,
  input  logic xfer_word,
  output logic xfer_ack,
  output logic xfer_err,
  output logic bus_req,
  input  logic bus_grant,
  output logic bus_clr,
  input  logic bus_byte,
  output logic cyc_go,
  output logic cyc_hi,
  input  logic cyc_done,
  input  logic bus_err,
  input  logic retry,
  input  logic halt,
  input  logic lat_release
);

  dbt_state_e state_q, state_n;
  logic       two_q, two_n;
  dbt_out_t   out_q, out_n;

  dbt_next u_next (
    .state_q   (state_q),
    .two_q     (two_q),
    .go_q      (out_q.cyc_go),
    .xfer_req  (xfer_req),
    .xfer_word (xfer_word),
    .bus_byte  (bus_byte),
    .bus_grant (bus_grant),
    .halt      (halt),
    .cyc_done  (cyc_done),
    .bus_err   (bus_err),
    .retry     (retry),
    .state_n   (state_n),
    .two_n     (two_n),
    .out_n     (out_n)
  );

  dbt_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .state_n (state_n),
    .two_n   (two_n),
    .out_n   (out_n),
    .state_q (state_q),
    .two_q   (two_q),
    .out_q   (out_q)
  );

  assign bus_req  = out_q.bus_req;
  assign bus_clr  = out_q.bus_clr;
  assign cyc_go   = out_q.cyc_go;
  assign cyc_hi   = out_q.cyc_hi;
  assign xfer_ack = out_q.ack;
  assign xfer_err = out_q.err;

endmodule

// File: rtl/dbt_checker.sv
module dbt_checker (
  input logic clk,
  input logic rst,
  input logic xfer_req,
  input logic xfer_ack,
  input logic xfer_err,
  input logic bus_req,
  input logic bus_clr,
  input logic cyc_go,
  input logic cyc_hi,
  input logic halt,
  input logic lat_release
);

  p_clr_with_req_r1: assert property (@(posedge clk) disable iff (rst)
    bus_clr |-> bus_req);

  p_clr_off_in_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    cyc_go |-> !bus_clr);

  p_ack_releases_r11: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> !bus_req);

  p_upper_holds_bus_r4: assert property (@(posedge clk) disable iff (rst)
    cyc_hi |-> bus_req);

  p_reset_clears_r6: assert property (@(posedge clk)
    rst |=> (!bus_req && !cyc_go && !xfer_ack && !xfer_err));

  p_halt_no_start_r7: assert property (@(posedge clk) disable iff (rst)
    (halt && !cyc_go) |=> !cyc_go);

  p_ack_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(xfer_ack && xfer_err));

  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |=> !xfer_ack);

  p_lat_no_request_r10: assert property (@(posedge clk) disable iff (rst)
    (lat_release && !bus_req && !xfer_req) |=> !bus_req);

endmodule

bind dma_bus_tenure dbt_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .xfer_req    (xfer_req),
  .xfer_ack    (xfer_ack),
  .xfer_err    (xfer_err),
  .bus_req     (bus_req),
  .bus_clr     (bus_clr),
  .cyc_go      (cyc_go),
  .cyc_hi      (cyc_hi),
  .halt        (halt),
  .lat_release (lat_release)
);

// File: tb/tb_dma_bus_tenure.sv
`timescale 1ns/1ps
module tb_dma_bus_tenure;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xfer_req = 0, xfer_word = 0, bus_grant = 0, bus_byte = 0;
  logic cyc_done = 0, bus_err = 0, retry = 0, halt = 0, lat_release = 0;
  logic xfer_ack, xfer_err, bus_req, bus_clr, cyc_go, cyc_hi;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_bus_tenure dut (
    .clk(clk), .rst(rst), .xfer_req(xfer_req), .xfer_word(xfer_word),
    .xfer_ack(xfer_ack), .xfer_err(xfer_err), .bus_req(bus_req),
    .bus_grant(bus_grant), .bus_clr(bus_clr), .bus_byte(bus_byte),
    .cyc_go(cyc_go), .cyc_hi(cyc_hi), .cyc_done(cyc_done),
    .bus_err(bus_err), .retry(retry), .halt(halt), .lat_release(lat_release)
  );

  // [5] word, [4] byte bus, [3:2] lower-beat event, [1:0] upper-beat event
  // event code: 0 none, 1 bus error, 2 retry
  localparam logic [5:0] VEC [0:7] = '{
    6'b00_00_00, 6'b10_00_00, 6'b01_00_00, 6'b11_00_00,
    6'b11_01_00, 6'b11_00_01, 6'b11_10_00, 6'b00_10_00
  };

  task automatic chk(input int act, input int exp, input string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic beat(input logic [1:0] ev);
    cyc_done = 1; bus_err = (ev == 2'd1); retry = (ev == 2'd2);
    @(negedge clk);
    cyc_done = 0; bus_err = 0; retry = 0;
  endtask

  task automatic run_op(input logic [5:0] v);
    bit two;
    int exp_ack, exp_err;
    two = v[5] && v[4] && (v[3:2] == 2'd0);
    if (v[3:2] != 2'd0) begin
      exp_ack = 0; exp_err = (v[3:2] == 2'd1);
    end else if (two) begin
      exp_ack = (v[1:0] == 2'd0); exp_err = (v[1:0] == 2'd1);
    end else begin
      exp_ack = 1; exp_err = 0;
    end
    @(negedge clk);
    xfer_req = 1; xfer_word = v[5]; bus_byte = v[4];
    @(negedge clk);
    xfer_req = 0;
    chk(bus_req, 1, "R1 bus_req while requesting");
    chk(bus_clr, 1, "R1 bus_clr while requesting");
    bus_grant = 1;
    @(negedge clk);
    chk(cyc_go, 1, "R2 access started");
    chk(bus_clr, 0, "R2 bus_clr during access");
    chk(cyc_hi, 0, "R4 lower byte first");
    beat(v[3:2]);
    if (two) begin
      chk(cyc_hi, 1, "R4 upper byte beat");
      chk(bus_req, 1, "R4 bus held between beats");
      chk(xfer_ack, 0, "R4 no ack after first half");
      beat(v[1:0]);
    end
    chk(xfer_ack, exp_ack, "R3/R9 ack at end of operand");
    chk(xfer_err, exp_err, "R8 error pulse");
    chk(bus_req, 0, "R3 bus released after one operand");
    chk(cyc_go, 0, "R5 no extra access");
    @(negedge clk);
    bus_grant = 0;
    chk(xfer_ack, 0, "R11 ack lasts one cycle");
    chk(bus_req, 0, "R3 idle after release");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_req, 0, "R6 reset bus_req");
    chk(cyc_go, 0, "R6 reset cyc_go");
    chk(xfer_ack, 0, "R6 reset ack");
    rst = 0;

    for (int i = 0; i < 8; i++) run_op(VEC[i]);

    // R10: the latency control changes nothing
    lat_release = 1;
    repeat (2) @(negedge clk);
    chk(bus_req, 0, "R10 lat_release alone no request");
    run_op(6'b11_00_00);
    run_op(6'b10_00_00);
    lat_release = 0;

    // R7: halt while idle holds off the request
    @(negedge clk);
    halt = 1; xfer_req = 1; xfer_word = 1; bus_byte = 1;
    repeat (2) @(negedge clk);
    chk(bus_req, 0, "R7 no request under halt");
    halt = 0;
    @(negedge clk);
    xfer_req = 0;
    chk(bus_req, 1, "R7 request after halt removed");
    bus_grant = 1;
    @(negedge clk);
    // R7: halt during a running access does not end it
    halt = 1;
    @(negedge clk);
    chk(cyc_go, 1, "R7 running access not cut");
    beat(2'd0);
    chk(cyc_hi, 1, "R7 upper beat pending");
    chk(cyc_go, 0, "R7 upper beat held by halt");
    repeat (2) @(negedge clk);
    chk(cyc_go, 0, "R7 still suspended");
    chk(bus_req, 1, "R7 bus kept while suspended");
    halt = 0;
    @(negedge clk);
    chk(cyc_go, 1, "R7 resumes after halt");
    beat(2'd0);
    chk(xfer_ack, 1, "R7 operand completes");
    @(negedge clk);
    bus_grant = 0;

    // R6: reset in the middle of an access
    xfer_req = 1; xfer_word = 1; bus_byte = 1;
    @(negedge clk);
    xfer_req = 0; bus_grant = 1;
    @(negedge clk);
    chk(cyc_go, 1, "R6 access running before reset");
    rst = 1;
    @(negedge clk);
    rst = 0; bus_grant = 0;
    chk(bus_req, 0, "R6 reset drops request");
    chk(cyc_go, 0, "R6 reset drops access");
    repeat (2) @(negedge clk);
    chk(bus_req, 0, "R6 nothing pending after reset");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule